// File: doc/BRIEF.md
# Laser Safety Fault Supervisor

This block is the digital safety controller that sits beside a laser driver. Each clock it compares a digitised monitor-photodiode sample against a nominal set point. If the sample stays outside a symmetric percentage window for a full timeout, the block raises a latched fault. While the fault is latched, it drives a clamp output that pulls the monitor-feedback node low. It also forces the laser off. The fault can only be cleared by driving the active-low laser-on control to its off level, and that same action restarts the timing.

Laser enable has three conditions. The laser-on control must be active (low). A separate power permission input must be high, so the laser stays dark until its bias is ready. No fault may be latched. The timeout is set in microseconds and scaled by a clock-frequency parameter, so the same block serves any system clock. The analog bias and modulation paths are outside this block.

A generate option adds one pipeline register after the window comparator for clocks where the comparison is too deep. This option delays fault detection by one cycle.

Top module: `laser_safety_supervisor`

## Requirements
- R1: `laser_en` is high only while `laser_on_n` is 0, `power_ok` is 1, `fault` is 0 and `rst` is 0. Under those conditions it is high in the same cycle, with no register in the enable path.
- R2: A sample is out of range when 100·|sample − nominal| > TOL_PCT·nominal, where TOL_PCT defaults to 10. A deviation of exactly TOL_PCT percent counts as inside the window. This holds for deviations both above and below the nominal value.
- R3: The timeout is TIMEOUT_CYC = CLK_KHZ·TIMEOUT_US/1000 cycles. `fault` rises on the clock edge that samples the out-of-range condition for the TIMEOUT_CYC-th consecutive time, and not before. This assumes `laser_on_n` = 0 and WINDOW_PIPE = 0; WINDOW_PIPE = 1 adds one cycle.
- R4: A single in-range sample before expiry restarts the count. A fault then needs another full TIMEOUT_CYC consecutive out-of-range samples.
- R5: Once `fault` is 1, it stays 1 for as long as `laser_on_n` stays 0, whatever the sample does.
- R6: `mon_clamp` is 1 (node pulled low) exactly while `fault` is latched.
- R7: A clock edge that samples `laser_on_n` = 1 clears `fault` and the timer. Timing restarts from zero once `laser_on_n` returns to 0.
- R8: With `power_ok` = 0, `laser_en` is 0, but fault detection and latching carry on unchanged.
- R9: During synchronous reset and after its release, `fault` and `mon_clamp` are 0. `laser_en` is held at 0 while `rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_sample | input | SAMPLE_W | Digitised monitor-feedback sample |
| mon_nominal | input | SAMPLE_W | Nominal monitor set point |
| laser_on_n | input | 1 | Laser-on control, active low; high clears the fault |
| power_ok | input | 1 | Power permission, laser held off while low |
| fault | output | 1 | Latched safety fault |
| laser_en | output | 1 | Laser driver enable |
| mon_clamp | output | 1 | Monitor-node clamp request, active while faulted |

## Verification
The bench builds the block with CLK_KHZ = 8, TIMEOUT_US = 2000, TOL_PCT = 10 and WINDOW_PIPE = 0. This gives a 16-cycle timeout, so the cycle on which the fault is declared, the one-short count and the restart after a single good sample can each be reached and checked within a few dozen clocks. With a nominal value of 100, the 10 % setting puts the window edges at exactly 90 and 110. The bench can therefore probe the inclusive boundaries on both sides and the first outside codes (89 and 111). Random segments of held samples then run many timeouts and clears against a bench model.

// File: rtl/lss_pkg.sv
package lss_pkg;
   localparam int PCT_SCALE = 100;

   function automatic int timeout_cycles(input int clk_khz, input int timeout_us);
      return (clk_khz * timeout_us) / 1000;
   endfunction

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/lss_window.sv
module lss_window #(
   parameter int SAMPLE_W    = 12,
   parameter int TOL_PCT     = 10,
   parameter bit WINDOW_PIPE = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] nominal,
   output logic                out_of_range
);
   localparam int PROD_W = SAMPLE_W + 8;

   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 24) begin : g_bad_width
         $error("lss_window: SAMPLE_W out of supported range");
      end
      if (TOL_PCT < 1 || TOL_PCT > 100) begin : g_bad_tol
         $error("lss_window: TOL_PCT must be 1..100");
      end
   endgenerate

   logic [SAMPLE_W-1:0] dev_abs;
   logic [PROD_W-1:0]   dev_scaled;
   logic [PROD_W-1:0]   tol_scaled;
   logic                oor_comb;

   always_comb begin
      if (sample >= nominal) dev_abs = sample - nominal;
      else                   dev_abs = nominal - sample;
      dev_scaled = PROD_W'(dev_abs) * PROD_W'(lss_pkg::PCT_SCALE);
      tol_scaled = PROD_W'(nominal) * PROD_W'(TOL_PCT);
      oor_comb   = dev_scaled > tol_scaled;
   end

   generate
      if (WINDOW_PIPE) begin : g_piped
         logic oor_q;
         always_ff @(posedge clk) begin
            if (rst) oor_q <= 1'b0;
            else     oor_q <= oor_comb;
         end
         assign out_of_range = oor_q;
      end else begin : g_direct
         assign out_of_range = oor_comb;
      end
   endgenerate

   // R2: a sample equal to nominal can never be flagged
   assert_center_inside_R2: assert property (@(posedge clk) disable iff (rst)
      (!WINDOW_PIPE && sample == nominal) |-> !out_of_range);
endmodule

// File: rtl/lss_timer.sv
module lss_timer #(
   parameter int LIMIT = 16,
   parameter int CNT_W = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic tick,
   output logic expire
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("lss_timer: LIMIT must be at least 1");
      end
      if ((1 << CNT_W) <= LIMIT) begin : g_bad_cnt
         $error("lss_timer: CNT_W too small for LIMIT");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clear || !tick) cnt <= '0;
      else if (cnt != TOP)       cnt <= cnt + 1'b1;
   end

   assign expire = tick && !clear && (cnt == LAST);

   // R4: a missing tick returns the count to zero
   assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
      (!tick && !clear) |=> !expire || (LIMIT == 1));
   // R3: the count never runs past the limit
   assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= TOP);
endmodule

// File: rtl/lss_fault_latch.sv
module lss_fault_latch (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic set,
   output logic fault
);
   always_ff @(posedge clk) begin
      if (rst || clear) fault <= 1'b0;
      else if (set)     fault <= 1'b1;
   end

   // R5: latched fault survives while not cleared
   assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (fault && !clear) |=> fault);
   // R7: a clear always empties the latch
   assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
      clear |=> !fault);
endmodule

// File: rtl/laser_safety_supervisor.sv
module laser_safety_supervisor #(
   parameter int SAMPLE_W    = 12,
   parameter int TOL_PCT     = 10,
   parameter int CLK_KHZ     = 50000,
   parameter int TIMEOUT_US  = 2000,
   parameter bit WINDOW_PIPE = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] mon_sample,
   input  logic [SAMPLE_W-1:0] mon_nominal,
   input  logic                laser_on_n,
   input  logic                power_ok,
   output logic                fault,
   output logic                laser_en,
   output logic                mon_clamp
);
   localparam int TIMEOUT_CYC = lss_pkg::timeout_cycles(CLK_KHZ, TIMEOUT_US);
   localparam int CNT_W       = lss_pkg::cnt_width(TIMEOUT_CYC);

   generate
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("laser_safety_supervisor: timeout rounds to zero cycles");
      end
   endgenerate

   logic oor;
   logic expire;
   logic fault_q;

   lss_window #(
      .SAMPLE_W   (SAMPLE_W),
      .TOL_PCT    (TOL_PCT),
      .WINDOW_PIPE(WINDOW_PIPE)
   ) u_window (
      .clk         (clk),
      .rst         (rst),
      .sample      (mon_sample),
      .nominal     (mon_nominal),
      .out_of_range(oor)
   );

   lss_timer #(
      .LIMIT(TIMEOUT_CYC),
      .CNT_W(CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .clear (laser_on_n),
      .tick  (oor),
      .expire(expire)
   );

   lss_fault_latch u_latch (
      .clk  (clk),
      .rst  (rst),
      .clear(laser_on_n),
      .set  (expire),
      .fault(fault_q)
   );

   assign fault     = fault_q;
   assign mon_clamp = fault_q;
   assign laser_en  = !rst && !laser_on_n && power_ok && !fault_q;

   // R1: a latched fault keeps the laser dark
   assert_fault_blocks_en_R1: assert property (@(posedge clk) disable iff (rst)
      fault |-> !laser_en);
   // R8: no permission, no laser
   assert_power_gate_R8: assert property (@(posedge clk) disable iff (rst)
      !power_ok |-> !laser_en);
   // R3: a fault only appears right after an out-of-range sample while armed
   assert_fault_after_oor_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(fault) |-> $past(oor && !laser_on_n));
   // R6: clamp only engages from an armed, out-of-range state
   assert_clamp_origin_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(mon_clamp) |-> $past(!laser_on_n && oor));
endmodule

// File: tb/test_laser_safety_supervisor.sv
module test_laser_safety_supervisor;
   localparam int W   = 12;
   localparam int TOL = 10;
   localparam int T   = 16; // 8 kHz * 2000 us / 1000

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] s = 12'd100;
   logic [W-1:0] n = 12'd100;
   logic on_n = 1'b0;
   logic pw = 1'b1;
   logic fault, laser_en, mon_clamp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   laser_safety_supervisor #(
      .SAMPLE_W(W), .TOL_PCT(TOL), .CLK_KHZ(8), .TIMEOUT_US(2000), .WINDOW_PIPE(1'b0)
   ) i_laser_safety_supervisor (
      .clk(clk), .rst(rst), .mon_sample(s), .mon_nominal(n),
      .laser_on_n(on_n), .power_ok(pw),
      .fault(fault), .laser_en(laser_en), .mon_clamp(mon_clamp)
   );

   function automatic bit out_f(input int smp, input int nom);
      int d;
      d = (smp >= nom) ? smp - nom : nom - smp;
      return (100 * d) > (TOL * nom);
   endfunction

   // bench reference for the requirement-level behaviour
   int m_cnt = 0;
   bit m_fault = 1'b0;
   always @(posedge clk) begin
      if (rst || on_n) begin
         m_cnt   <= 0;
         m_fault <= 1'b0;
      end else if (out_f(int'(s), int'(n))) begin
         if (m_cnt == T - 1) m_fault <= 1'b1;
         if (m_cnt < T) m_cnt <= m_cnt + 1;
      end else begin
         m_cnt <= 0;
      end
   end

   function automatic bit exp_en();
      return !rst && !on_n && pw && !m_fault;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic cyc(input int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input int smp, input int nom, input bit onn, input bit p);
      s = W'(smp); n = W'(nom); on_n = onn; pw = p;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      drive(100, 100, 1'b0, 1'b1);
      cyc(3);
      chk("R9 laser_en in reset", laser_en, 1'b0);
      chk("R9 fault in reset", fault, 1'b0);
      chk("R9 clamp in reset", mon_clamp, 1'b0);
      rst = 1'b0;
      cyc(1);
      chk("R9 fault after reset", fault, 1'b0);
      chk("R1 enable when armed", laser_en, 1'b1);
      pw = 1'b0; #1;
      chk("R8 power low disables", laser_en, 1'b0);
      pw = 1'b1; #1;
      on_n = 1'b1; #1;
      chk("R1 laser_on_n high disables", laser_en, 1'b0);
      cyc(1);
      on_n = 1'b0;

      // R2 upper boundary: exactly 10% stays inside
      drive(110, 100, 1'b0, 1'b1);
      cyc(3 * T);
      chk("R2 110 of 100 inside", fault, 1'b0);
      drive(111, 100, 1'b0, 1'b1);
      cyc(T - 1);
      chk("R3 one short of timeout", fault, 1'b0);
      cyc(1);
      chk("R3 fault at timeout", fault, 1'b1);
      chk("R6 clamp while faulted", mon_clamp, 1'b1);
      chk("R1 fault blocks enable", laser_en, 1'b0);
      drive(100, 100, 1'b0, 1'b1);
      cyc(5);
      chk("R5 fault held after recovery", fault, 1'b1);
      chk("R6 clamp held", mon_clamp, 1'b1);

      // R7 clear via laser_on_n
      on_n = 1'b1;
      cyc(1);
      chk("R7 fault cleared", fault, 1'b0);
      chk("R7 clamp cleared", mon_clamp, 1'b0);
      on_n = 1'b0; #1;
      chk("R1 re-enabled after clear", laser_en, 1'b1);

      // R2 lower boundary
      drive(90, 100, 1'b0, 1'b1);
      cyc(3 * T);
      chk("R2 90 of 100 inside", fault, 1'b0);
      drive(89, 100, 1'b0, 1'b1);
      cyc(T);
      chk("R2 89 of 100 outside", fault, 1'b1);

      // R7 timing restarts after clear
      on_n = 1'b1;
      cyc(1);
      on_n = 1'b0;
      cyc(T - 1);
      chk("R7 count restarted", fault, 1'b0);
      cyc(1);
      chk("R7 full timeout after clear", fault, 1'b1);
      on_n = 1'b1;
      cyc(1);
      on_n = 1'b0;

      // R4 single good sample restarts the count
      drive(111, 100, 1'b0, 1'b1);
      cyc(T - 1);
      drive(100, 100, 1'b0, 1'b1);
      cyc(1);
      drive(111, 100, 1'b0, 1'b1);
      cyc(T - 1);
      chk("R4 restart after good sample", fault, 1'b0);
      cyc(1);
      chk("R4 fault after fresh timeout", fault, 1'b1);
      on_n = 1'b1;
      cyc(1);

      // R8 detection continues with power low
      drive(300, 200, 1'b0, 1'b0);
      cyc(1);
      chk("R8 enable low without power", laser_en, 1'b0);
      cyc(T - 1);
      chk("R8 fault with power low", fault, 1'b1);
      on_n = 1'b1;
      cyc(1);

      // random segments against the bench model
      void'($urandom(32'h5AFE_1A5E));
      for (int seg = 0; seg < 200; seg++) begin
         int nom, smp, len;
         bit onn, p;
         nom = 50 + int'($urandom_range(900));
         case ($urandom_range(3))
            0: smp = nom;
            1: smp = nom + int'($urandom_range(nom / 5));
            2: smp = nom - int'($urandom_range(nom / 5));
            default: smp = int'($urandom_range(4000));
         endcase
         onn = ($urandom_range(9) == 0);
         p   = ($urandom_range(4) != 0);
         len = 1 + int'($urandom_range(2 * T));
         drive(smp, nom, onn, p);
         for (int k = 0; k < len; k++) begin
            cyc(1);
            chk("R3 random fault", fault, m_fault);
            chk("R6 random clamp", mon_clamp, m_fault);
            chk("R1 random enable", laser_en, exp_en());
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule